// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes an incoming Ethernet frame, presented one byte per transfer with a marker on the final byte, and decides from the destination address whether the frame is wanted. It places accepted frames in host memory through a ring of 16-byte receive descriptors. Software prepares each descriptor with a buffer pointer and a negative buffer length, and hands it to the engine by setting an ownership bit. The engine spreads the frame across as many owned descriptors as it needs. It writes status and the byte count back, returns ownership, and then pulses a receive-interrupt event.

The memory side is one 32-bit word port with byte enables. It uses a request/acknowledge handshake, and reads return data with the acknowledge. Configuration comes from static inputs: an enable, the ring base, the ring length, the descriptor layout select, the station address and a promiscuous flag. The input stream is held off with `in_ready` while the engine waits on memory, so no frame byte is lost while a descriptor is being read.

Top module: `rx_ring_dma`

## Requirements
- R1: A frame is accepted when `cfg_promisc` is 1, or when bit 0 of its first byte is 1 (multicast), or when its first six bytes equal `cfg_station` exactly, with the first byte compared against `cfg_station[7:0]`. Any other frame is consumed and causes no memory write and no `rx_int`.
- R2: When `cfg_rx_enable` is 0 or `cfg_ring_base` is 0, a frame is consumed in full with no memory access and no `rx_int`.
- R3: The descriptor at position p lies at `cfg_ring_base + 16*p`. After a completed frame the position moves one past the last descriptor used, and it wraps to 0 on reaching `cfg_ring_len`. Position resets to 0.
- R4: Descriptor word 1 bits 11:0 hold the buffer size as a two's-complement negative number. Frame bytes are packed little-endian into 32-bit words starting at the word-aligned buffer address. Bytes outside the frame or past the buffer size are never written.
- R5: If the descriptor at the current position lacks OWN (word 1 bit 31), the frame is dropped. No memory is written and the position is unchanged.
- R6: When a buffer fills and more frame bytes remain, the next descriptor is fetched if it is owned. The filled descriptor, unless it is the first one, has OWN cleared in its word 1.
- R7: If that next descriptor is not owned, the current descriptor's word 1 gets ERR (bit 30), BUFF (bit 27) and ENP (bit 24) with OWN cleared (unless it is the first), and its count word is left alone. The rest of the frame is discarded, and the position stays on the unowned descriptor.
- R8: On a normal end, the last descriptor gets ENP in word 1. Its count word bits 11:0 become the stored length plus 4, and bits 31:12 keep the value read.
- R9: The first descriptor's word 1 is written last, with OWN cleared and STP (bit 25) set. `rx_int` then pulses high for one cycle.
- R10: With `cfg_layout_swap` = 0 the buffer address is descriptor word 0 and the count is word 2. With 1 these two words trade places.
- R11: At most `MAX_FRAME` (2048) bytes are stored, and the byte count reflects the stored length. Later bytes are consumed and discarded.
- R12: After reset `mem_req`, `rx_int` and `in_ready` are 0. A memory request holds its address, direction and data until `mem_ack`. No input byte is taken while a request is pending.
- R13: A frame that ends before its sixth byte is dropped without memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_enable | input | 1 | Reception enable |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_ring_len | input | POS_W+1 | Number of descriptors in the ring |
| cfg_layout_swap | input | 1 | Descriptor layout select (buffer address/count word swap) |
| cfg_station | input | 48 | Station address, first wire byte in bits 7:0 |
| cfg_promisc | input | 1 | Accept every frame |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte taken at this edge when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| rx_int | output | 1 | Receive-complete event pulse |

## Verification
Destination addresses are swept by flipping every bit of the station address, in both promiscuous settings. Multicast and exact-match frames are also sent, so each clause of the filter is exercised separately. Frames are sized to fit one buffer, to span three buffers, to hit an unowned successor, to meet a six-byte buffer that ends mid-word, and to run past the storage limit. These cases separate the chaining, error and byte-enable paths. Further frames follow on from the previous ones to show where the ring position ends up after completion, after a buffer error, after an unowned first descriptor and after wrapping. Both descriptor layouts are checked by where the count lands.

// File: rtl/rx_ring_dma_pkg.sv
`timescale 1ns/1ps
package rx_ring_dma_pkg;
  localparam int LEN_W    = 12;
  localparam int BIT_OWN  = 31;
  localparam int BIT_ERR  = 30;
  localparam int BIT_BUFF = 27;
  localparam int BIT_STP  = 25;
  localparam int BIT_ENP  = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_RD1, S_RDA, S_RDC, S_DATA, S_WRW,
    S_NXT, S_WB1, S_WBC, S_WBF, S_DRAIN
  } dma_st_t;

  typedef enum logic [1:0] { K_CHAIN, K_END, K_ERR } wb_kind_t;

  // buffer size from the negated length field
  function automatic logic [LEN_W-1:0] buf_bytes(input logic [31:0] w1);
    return LEN_W'(0) - w1[LEN_W-1:0];
  endfunction

  // byte address of a descriptor slot
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] pos);
    return base + (pos << 4);
  endfunction
endpackage

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter (
  input  logic [47:0] dest,
  input  logic [47:0] station,
  input  logic        promisc,
  output logic        accept
);
  assign accept = promisc | dest[0] | (dest == station);
endmodule

// File: rtl/rx_ring_ptr.sv
`timescale 1ns/1ps
module rx_ring_ptr #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ring_base,
  input  logic [POS_W:0]   ring_len,
  input  logic             step,
  output logic [31:0]      desc_addr
);
  import rx_ring_dma_pkg::*;
  logic [POS_W-1:0] pos;
  logic [POS_W:0]   pos_inc;

  assign pos_inc   = {1'b0, pos} + 1'b1;
  assign desc_addr = slot_addr(ring_base, 32'(pos));

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= (pos_inc >= ring_len) ? '0 : pos_inc[POS_W-1:0];
  end
endmodule

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma #(
  parameter int POS_W     = 9,
  parameter int MAX_FRAME = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rx_enable,
  input  logic [31:0]      cfg_ring_base,
  input  logic [POS_W:0]   cfg_ring_len,
  input  logic             cfg_layout_swap,
  input  logic [47:0]      cfg_station,
  input  logic             cfg_promisc,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             rx_int
);
  import rx_ring_dma_pkg::*;

  localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(MAX_FRAME - 1);

  dma_st_t          st;
  wb_kind_t         kind;
  logic [47:0]      hdr;
  logic [2:0]       hcnt, rep;
  logic             hdr_last, saw_last, p_eos, p_bfull, cur_first;
  logic [31:0]      acc, waddr, cur_ptr, cur_w1, cur_cw, first_ptr, first_w1, nxt_w1;
  logic [3:0]       be;
  logic [1:0]       lane;
  logic [LEN_W-1:0] rem, cnt;
  logic [31:0]      ring_addr, wb1_val, wbf_val, off_addr, off_cnt;
  logic             accept, step, take, src_last, eos_now, bfull_now;
  logic [7:0]       src_byte;
  // named events for the checker
  logic             ev_take, ev_hand_back;

  rx_addr_filter u_filt (
    .dest(({in_data, hdr[39:0]})), .station(cfg_station),
    .promisc(cfg_promisc), .accept(accept)
  );

  rx_ring_ptr #(.POS_W(POS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_base(cfg_ring_base),
    .ring_len(cfg_ring_len), .step(step), .desc_addr(ring_addr)
  );

  assign off_addr  = cfg_layout_swap ? 32'd8 : 32'd0;
  assign off_cnt   = cfg_layout_swap ? 32'd0 : 32'd8;
  assign in_ready  = (st == S_HDR) || (st == S_DRAIN) ||
                     (st == S_DATA && rep == 3'd6 && !saw_last);
  assign src_byte  = (rep < 3'd6) ? hdr[{rep, 3'b000} +: 8] : in_data;
  assign src_last  = (rep < 3'd6) ? (rep == 3'd5 && hdr_last) : in_last;
  assign take      = (st == S_DATA) && ((rep < 3'd6) || (in_valid && !saw_last));
  assign eos_now   = src_last || (cnt == LAST_IDX);
  assign bfull_now = (rem == LEN_W'(1));
  assign step      = mem_ack && ((st == S_WRW && !p_eos && p_bfull) ||
                                 (st == S_WB1 && kind == K_END));
  assign ev_take      = take;
  assign ev_hand_back = (st == S_WBF);

  always_comb begin
    wb1_val = cur_w1;
    if (!cur_first)    wb1_val[BIT_OWN] = 1'b0;
    if (kind != K_CHAIN) wb1_val[BIT_ENP] = 1'b1;
    if (kind == K_ERR) begin
      wb1_val[BIT_ERR]  = 1'b1;
      wb1_val[BIT_BUFF] = 1'b1;
    end
    wbf_val = cur_first ? wb1_val : first_w1;
    wbf_val[BIT_OWN] = 1'b0;
    wbf_val[BIT_STP] = 1'b1;
  end

  always_comb begin
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_be = 4'hF;
    unique case (st)
      S_RD1:   mem_addr = cur_ptr + 32'd4;
      S_RDA:   mem_addr = cur_ptr + off_addr;
      S_RDC:   mem_addr = cur_ptr + off_cnt;
      S_NXT:   mem_addr = ring_addr + 32'd4;
      S_WRW:   begin mem_we = 1'b1; mem_addr = waddr; mem_wdata = acc; mem_be = be; end
      S_WB1:   begin mem_we = 1'b1; mem_addr = cur_ptr + 32'd4; mem_wdata = wb1_val; end
      S_WBC:   begin
        mem_we = 1'b1; mem_addr = cur_ptr + off_cnt;
        mem_wdata = {cur_cw[31:LEN_W], LEN_W'(cnt + LEN_W'(4))};
      end
      S_WBF:   begin mem_we = 1'b1; mem_addr = first_ptr + 32'd4; mem_wdata = wbf_val; end
      default: begin mem_req = 1'b0; mem_be = 4'h0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_CHAIN; hdr <= '0; hcnt <= '0; rep <= '0;
      hdr_last <= 1'b0; saw_last <= 1'b0; p_eos <= 1'b0; p_bfull <= 1'b0;
      cur_first <= 1'b0; acc <= '0; be <= '0; lane <= '0; waddr <= '0;
      cur_ptr <= '0; cur_w1 <= '0; cur_cw <= '0; first_ptr <= '0;
      first_w1 <= '0; nxt_w1 <= '0; rem <= '0; cnt <= '0; rx_int <= 1'b0;
    end else begin
      rx_int <= 1'b0;
      unique case (st)
        S_IDLE: begin
          hdr <= '0; hcnt <= '0; rep <= '0; saw_last <= 1'b0;
          if (in_valid)
            st <= (!cfg_rx_enable || cfg_ring_base == '0) ? S_DRAIN : S_HDR;
        end
        S_HDR: if (in_valid) begin
          hdr[{hcnt, 3'b000} +: 8] <= in_data;
          hcnt <= hcnt + 3'd1;
          if (hcnt == 3'd5) begin
            hdr_last <= in_last;
            saw_last <= in_last;
            if (accept) begin cur_ptr <= ring_addr; st <= S_RD1; end
            else st <= in_last ? S_IDLE : S_DRAIN;
          end else if (in_last) st <= S_IDLE;
        end
        S_RD1: if (mem_ack) begin
          if (mem_rdata[BIT_OWN]) begin
            cur_w1 <= mem_rdata; first_w1 <= mem_rdata; first_ptr <= cur_ptr;
            cur_first <= 1'b1; cnt <= '0; lane <= '0; be <= '0; acc <= '0;
            st <= S_RDA;
          end else st <= saw_last ? S_IDLE : S_DRAIN;
        end
        S_RDA: if (mem_ack) begin
          waddr <= {mem_rdata[31:2], 2'b00};
          rem   <= buf_bytes(cur_w1);
          st    <= S_RDC;
        end
        S_RDC: if (mem_ack) begin cur_cw <= mem_rdata; st <= S_DATA; end
        S_DATA: if (take) begin
          acc[{lane, 3'b000} +: 8] <= src_byte;
          be[lane] <= 1'b1;
          lane <= lane + 2'd1;
          cnt  <= cnt + LEN_W'(1);
          rem  <= rem - LEN_W'(1);
          if (rep < 3'd6) rep <= rep + 3'd1;
          else if (in_last) saw_last <= 1'b1;
          if (eos_now || bfull_now || lane == 2'd3) begin
            p_eos <= eos_now; p_bfull <= bfull_now; st <= S_WRW;
          end
        end
        S_WRW: if (mem_ack) begin
          acc <= '0; be <= '0; lane <= '0; waddr <= waddr + 32'd4;
          if (p_eos) begin kind <= K_END; st <= S_WB1; end
          else st <= p_bfull ? S_NXT : S_DATA;
        end
        S_NXT: if (mem_ack) begin
          nxt_w1 <= mem_rdata;
          kind   <= mem_rdata[BIT_OWN] ? K_CHAIN : K_ERR;
          st     <= S_WB1;
        end
        S_WB1: if (mem_ack) begin
          unique case (kind)
            K_CHAIN: begin
              cur_ptr <= ring_addr; cur_w1 <= nxt_w1; cur_first <= 1'b0; st <= S_RDA;
            end
            K_END:   st <= S_WBC;
            default: st <= S_WBF;
          endcase
        end
        S_WBC: if (mem_ack) st <= S_WBF;
        S_WBF: if (mem_ack) begin
          rx_int <= 1'b1;
          st <= saw_last ? S_IDLE : S_DRAIN;
        end
        S_DRAIN: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
`timescale 1ns/1ps
module rx_ring_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        rx_int,
  input logic        ev_take,
  input logic        ev_hand_back
);
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r12_no_ready_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);
  a_r12_no_take_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> !mem_req);
  a_r4_write_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0);
  a_r9_int_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |=> !rx_int);
  a_r9_int_after_handback: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hand_back && mem_ack |=> rx_int);
  a_r9_int_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> $past(mem_we && mem_ack));
endmodule

bind rx_ring_dma rx_ring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_be(mem_be), .rx_int(rx_int),
  .ev_take(ev_take), .ev_hand_back(ev_hand_back)
);

// File: tb/rx_ring_dma_bench.sv
`timescale 1ns/1ps
module rx_ring_dma_bench;
  localparam logic [31:0] RING = 32'h100;
  localparam logic [31:0] CW0  = 32'h5A00_0000;
  localparam logic [47:0] STA  = 48'h6655_4433_2212;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b1, swap = 1'b0, promisc = 1'b0;
  logic [31:0] base = RING;
  logic [9:0]  rlen = 10'd4;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, rx_int;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic ack_r = 1'b0;
  logic [31:0] rd_r = '0;
  logic [31:0] mem [0:2047];
  logic [47:0] da_cur = STA;
  int n_chk = 0, n_fail = 0, n_int = 0, pre = 0;
  bit done = 0;

  rx_ring_dma u_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .cfg_rx_enable(en), .cfg_ring_base(base),
    .cfg_ring_len(rlen), .cfg_layout_swap(swap), .cfg_station(STA),
    .cfg_promisc(promisc), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(rd_r), .mem_ack(ack_r), .rx_int(rx_int)
  );

  always @(posedge clk) begin
    if (!rst_n) ack_r <= 1'b0;
    else begin
      ack_r <= mem_req && !ack_r;
      if (mem_req && !ack_r) begin
        if (mem_we)
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[12:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
        rd_r <= mem[mem_addr[12:2]];
      end
    end
    if (rst_n && rx_int) n_int <= n_int + 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w1_of(input int len);
    return 32'h8000_0000 | ((32'h0 - 32'(len)) & 32'hFFF);
  endfunction

  function automatic logic [31:0] dw(input int idx, input int k);
    return mem[(RING >> 2) + idx*4 + k];
  endfunction

  function automatic logic [7:0] fbyte(input int i, input int seed);
    if (i < 6) return da_cur[8*i +: 8];
    return 8'(seed + i*3);
  endfunction

  function automatic logic [7:0] get_byte(input logic [31:0] a);
    return mem[a[12:2]][8*a[1:0] +: 8];
  endfunction

  task automatic arm(input int idx, input bit own, input int len, input logic [31:0] baddr);
    int a = (RING >> 2) + idx*4;
    mem[a + 1] = own ? w1_of(len) : (w1_of(len) & 32'h7FFF_FFFF);
    mem[a + (swap ? 2 : 0)] = baddr;
    mem[a + (swap ? 0 : 2)] = CW0;
    mem[a + 3] = '0;
  endtask

  task automatic send(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fbyte(i, seed); in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_data(input logic [31:0] ba, input int from, input int cnt, input int seed, input string tag);
    for (int j = 0; j < cnt; j++) chk(32'(get_byte(ba + 32'(j))), 32'(fbyte(from + j, seed)), tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    en = 1'b1; base = RING; swap = 1'b0; promisc = 1'b0; da_cur = STA;
    for (int i = 0; i < 2048; i++) mem[i] = 32'hEEEE_EEEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    chk(32'(mem_req), 0, "R12 reset mem_req");
    chk(32'(rx_int), 0, "R12 reset rx_int");
    chk(32'(in_ready), 0, "R12 reset in_ready");

    // single descriptor, exact station match
    arm(0, 1, 64, 32'h400);
    pre = n_int; send(21, 1);
    chk_data(32'h400, 0, 21, 1, "R4 single data");
    chk(32'(get_byte(32'h415)), 32'hEE, "R4 untouched byte after frame");
    chk(32'(get_byte(32'h417)), 32'hEE, "R4 untouched byte end of word");
    chk(dw(0, 1), 32'h0300_0FC0, "R9 first desc handed back");
    chk(dw(0, 2), CW0 | 32'd25, "R8 count word");
    chk(32'(n_int - pre), 1, "R9 one interrupt");

    // swapped layout
    do_reset(); swap = 1'b1;
    arm(0, 1, 64, 32'h400);
    send(21, 2);
    chk(dw(0, 0), CW0 | 32'd25, "R10 count in word0");
    chk(dw(0, 2), 32'h400, "R10 address word kept");
    chk_data(32'h400, 0, 21, 2, "R10 data via word2");

    // three-buffer chain then ring wrap
    do_reset();
    arm(0, 1, 8, 32'h400); arm(1, 1, 8, 32'h500); arm(2, 1, 8, 32'h600);
    pre = n_int; send(20, 3);
    chk(dw(0, 1), 32'h0200_0FF8, "R9 chain first desc");
    chk(dw(1, 1), 32'h0000_0FF8, "R6 middle own cleared");
    chk(dw(2, 1), 32'h0100_0FF8, "R8 last desc enp");
    chk(dw(2, 2), CW0 | 32'd24, "R8 chain count");
    chk(dw(0, 2), CW0, "R8 first count untouched");
    chk_data(32'h400, 0, 8, 3, "R6 chunk0");
    chk_data(32'h500, 8, 8, 3, "R6 chunk1");
    chk_data(32'h600, 16, 4, 3, "R6 chunk2");
    chk(32'(n_int - pre), 1, "R9 chain interrupt");
    arm(3, 1, 64, 32'h700);
    send(10, 5);
    chk(dw(3, 1), 32'h0300_0FC0, "R3 next frame in slot3");
    chk_data(32'h700, 0, 10, 5, "R3 slot3 data");
    for (int i = 0; i < 16; i++) mem[(32'h400 >> 2) + i] = 32'hEEEE_EEEE;
    arm(0, 1, 64, 32'h400);
    send(9, 9);
    chk(dw(0, 2), CW0 | 32'd13, "R3 wrap to slot0");
    chk_data(32'h400, 0, 9, 9, "R3 wrap data");

    // unowned successor
    do_reset();
    arm(0, 1, 8, 32'h400); arm(1, 1, 8, 32'h500); arm(2, 0, 8, 32'h600);
    pre = n_int; send(20, 4);
    chk(dw(1, 1), 32'h4900_0FF8, "R7 err buff enp");
    chk(dw(1, 2), CW0, "R7 count untouched");
    chk(dw(0, 1), 32'h0200_0FF8, "R9 first after error");
    chk_data(32'h400, 0, 8, 4, "R7 data0");
    chk_data(32'h500, 8, 8, 4, "R7 data1");
    chk(32'(n_int - pre), 1, "R7 interrupt");
    arm(2, 1, 64, 32'h600);
    send(8, 6);
    chk(dw(2, 1), 32'h0300_0FC0, "R7 position on unowned slot");
    chk(dw(2, 2), CW0 | 32'd12, "R7 next frame count");

    // first descriptor not owned
    do_reset();
    arm(0, 0, 64, 32'h400);
    pre = n_int; send(12, 7);
    chk(dw(0, 1), 32'h0000_0FC0, "R5 desc unchanged");
    chk(mem[32'h400 >> 2], 32'hEEEE_EEEE, "R5 buffer untouched");
    chk(32'(n_int - pre), 0, "R5 no interrupt");
    arm(0, 1, 64, 32'h400);
    send(12, 7);
    chk(dw(0, 1), 32'h0300_0FC0, "R5 position unchanged");

    // odd buffer size, partial word
    do_reset();
    arm(0, 1, 6, 32'h400); arm(1, 1, 64, 32'h500);
    send(10, 8);
    chk_data(32'h400, 0, 6, 8, "R4 odd buffer data");
    chk(32'(get_byte(32'h406)), 32'hEE, "R4 byte past buffer");
    chk(32'(get_byte(32'h407)), 32'hEE, "R4 byte past buffer end");
    chk_data(32'h500, 6, 4, 8, "R4 odd tail data");
    chk(dw(0, 1), 32'h0200_0FFA, "R9 odd first");
    chk(dw(1, 1), 32'h0100_0FC0, "R8 odd last");
    chk(dw(1, 2), CW0 | 32'd14, "R8 odd count");

    // disabled and zero base
    do_reset();
    arm(0, 1, 64, 32'h400);
    en = 1'b0; pre = n_int; send(12, 1);
    chk(32'(n_int - pre), 0, "R2 disabled no interrupt");
    chk(dw(0, 1), w1_of(64), "R2 disabled desc untouched");
    en = 1'b1; base = 32'h0; send(12, 1);
    chk(32'(n_int - pre), 0, "R2 zero base no interrupt");
    chk(dw(0, 1), w1_of(64), "R2 zero base desc untouched");
    base = RING;

    // short frame
    send(4, 1);
    chk(32'(n_int - pre), 0, "R13 short frame dropped");
    chk(dw(0, 1), w1_of(64), "R13 desc untouched");
    send(12, 1);
    chk(32'(n_int - pre), 1, "R13 recovery frame accepted");

    // filter sweep
    do_reset();
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 6; k++) begin
        for (int b = 0; b < 8; b++) begin
          if (k == 0 && b == 0) continue;
          promisc = p[0];
          for (int d = 0; d < 4; d++) arm(d, 1, 64, 32'h400 + 32'(d) * 32'h100);
          da_cur = STA ^ (48'd1 << (8*k + b));
          pre = n_int; send(12, k);
          chk(32'(n_int - pre), 32'(p), $sformatf("R1 mismatch byte%0d bit%0d promisc%0d", k, b, p));
        end
      end
    end
    promisc = 1'b0;
    for (int d = 0; d < 4; d++) arm(d, 1, 64, 32'h400 + 32'(d) * 32'h100);
    da_cur = STA ^ 48'd1;
    pre = n_int; send(12, 2);
    chk(32'(n_int - pre), 1, "R1 multicast accepted");
    da_cur = STA;
    pre = n_int; send(12, 2);
    chk(32'(n_int - pre), 1, "R1 exact match accepted");

    // truncation
    do_reset();
    arm(0, 1, 2100, 32'h1000);
    send(2050, 11);
    chk(dw(0, 1), 32'h0300_07CC, "R11 truncated first desc");
    chk(dw(0, 2), CW0 | 32'd2052, "R11 truncated count");
    chk(32'(get_byte(32'h1800)), 32'hEE, "R11 byte past limit");
    chk_data(32'h1000, 0, 2048, 11, "R11 stored data");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule